// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block converts interrupt events raised by up to `NUM_SRC` sources inside a device function into in-band memory-write requests of the single-address message style. Every request carries the address that software programmed and a data word built from the programmed base value. When software grants fewer messages than the function asked for, the source number is folded onto the granted power-of-two count and written into the low bits of the data word. Several sources can therefore share one message value.

Each source keeps three state bits: pending, masked and outstanding. An event sets the pending bit. A pending source that is unmasked and not outstanding becomes eligible while the global enable is set. The lowest-indexed eligible source is loaded into a single output request register. Loading it clears its pending bit and marks it outstanding. The source stays silent until its service-acknowledge pulse arrives. The request register uses a valid/ready handshake and expects no response: each write is posted.

Top module: `msi_gen`

## Requirements
- R1: After reset `req_valid` is 0 and every pending, mask and outstanding bit is 0, so `pending_o` and `mask_o` read 0.
- R2: A 1 on `src_evt[i]` at a clock edge sets pending bit i, which shows on `pending_o[i]` after that edge. Further events on a source that is already pending merge into the same pending bit.
- R3: A request carries `req_addr` equal to `cfg_addr` and a `req_data` word in which the low g bits of `cfg_data` are replaced by the low g bits of the source index. g is `cfg_grant_log2`, clamped to log2(`NUM_SRC`) (5 by default). Both values are sampled in the cycle the request is loaded.
- R4: When source i's request is loaded, source i becomes outstanding. It loads no further request until a 1 on `svc_ack[i]` clears the outstanding bit. Events that arrive in the meantime stay pending and are sent after the acknowledge.
- R5: A 1 on `mask_set[i]` sets mask bit i and a 1 on `mask_clr[i]` clears it. Set wins when both are 1. The mask shows on `mask_o`. A masked pending source is not sent, and it is sent after its mask is cleared.
- R6: When several sources are eligible, the lowest index is loaded first, and at most one source is loaded per edge.
- R7: While `cfg_en` is 0 no request is loaded and pending bits are kept. A request that is already valid stays until it is accepted.
- R8: While `req_valid` is 1 and `req_ready` is 0, the request is held with its address and data unchanged. A handshake retires exactly one request. With the register idle, an event sampled at one edge produces `req_valid` after the next edge.
- R9: The pending bit of a source clears at the edge where its request is loaded, unless a new event arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Global message enable |
| cfg_addr | input | ADDR_W | Message target address |
| cfg_data | input | DATA_W | Base data value |
| cfg_grant_log2 | input | GW | log2 of the granted message count |
| src_evt | input | NUM_SRC | Per-source event pulses |
| svc_ack | input | NUM_SRC | Per-source serviced pulses |
| mask_set | input | NUM_SRC | Per-source mask set pulses |
| mask_clr | input | NUM_SRC | Per-source mask clear pulses |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Write request accepted when high with valid |
| req_addr | output | ADDR_W | Write address |
| req_data | output | DATA_W | Write data |
| pending_o | output | NUM_SRC | Pending bits for software readback |
| mask_o | output | NUM_SRC | Mask bits for software readback |

## Verification
The assertions check four properties on every cycle:
- a waiting request keeps its address and data;
- nothing is loaded while the enable is off;
- at most one source is chosen per edge, and only an eligible one (pending, unmasked, not outstanding);
- a chosen source becomes outstanding and its pending bit clears.

Three behaviours need the bench's scenarios to show them:
- the folded data values for each granted count, including the clamp;
- that a masked or outstanding event is released later rather than lost;
- the lowest-index-first order across sources.

The bench's cycle model compares every output, every cycle, against values computed from the requirements.

// File: rtl/msi_gen_pkg.sv
// Shared helpers for the MSI message generator.
package msi_gen_pkg;
    // Mask with the low g bits set (g up to 31).
    function automatic logic [31:0] low_mask(input int unsigned g);
        return (32'h1 << g) - 32'h1;
    endfunction
endpackage

// File: rtl/msi_src_slice.sv
// Per-source state: pending, outstanding and mask bits.
// Assumes take is only asserted for a source that is eligible.
module msi_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic svc,
    input  logic mset,
    input  logic mclr,
    input  logic take,
    output logic pend,
    output logic outs,
    output logic mask
);
    // Update the three state bits; new events, loads and mask set take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            outs <= 1'b0;
            mask <= 1'b0;
        end else begin
            pend <= evt | (pend & ~take);
            outs <= take | (outs & ~svc);
            mask <= mset | (mask & ~mclr);
        end
    end
endmodule

// File: rtl/msi_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
// Output is one-hot (or zero) plus the binary index of the winner.
module msi_prio_pick #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top down so the lowest set index is the last written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
        gnt = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/msi_req_reg.sv
// Output request register with valid/ready handshake and data folding.
// Assumes load is only asserted when can_load is high.
module msi_req_reg #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16,
    parameter int IW      = 5,
    parameter int GW      = 3,
    parameter int SRC_LOG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IW-1:0]     idx,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] base_in,
    input  logic [GW-1:0]     glog,
    input  logic              ready,
    output logic              can_load,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    import msi_gen_pkg::*;

    logic [GW-1:0]     g_eff;
    logic [DATA_W-1:0] fold_msk;
    logic [DATA_W-1:0] folded;

    // Clamp the granted count and build the folded data word.
    always_comb begin
        g_eff    = (glog > GW'(SRC_LOG)) ? GW'(SRC_LOG) : glog;
        fold_msk = DATA_W'(low_mask(int'(g_eff)));
        folded   = (base_in & ~fold_msk) | (DATA_W'(idx) & fold_msk);
    end

    assign can_load = !valid || ready;

    // Hold the request until accepted; reload when a new source is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= addr_in;
            data  <= folded;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/msi_gen.sv
// MSI message generator top: per-source state, priority pick, request register.
// Assumes NUM_SRC is a power of two from 1 to 32 and DATA_W >= log2(NUM_SRC).
module msi_gen #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16,
    localparam int SRC_LOG = $clog2(NUM_SRC),
    localparam int IW      = (SRC_LOG > 0) ? SRC_LOG : 1,
    localparam int GW      = $clog2(SRC_LOG + 1) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_data,
    input  logic [GW-1:0]      cfg_grant_log2,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] svc_ack,
    input  logic [NUM_SRC-1:0] mask_set,
    input  logic [NUM_SRC-1:0] mask_clr,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_data,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] outs_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] take;
    logic [IW-1:0]      win_idx;
    logic               win_any;
    logic               can_load;

    // One state slice per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        msi_src_slice u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (src_evt[i]),
            .svc  (svc_ack[i]),
            .mset (mask_set[i]),
            .mclr (mask_clr[i]),
            .take (take[i]),
            .pend (pend_q[i]),
            .outs (outs_q[i]),
            .mask (mask_q[i])
        );
    end

    // Eligible: pending, unmasked, not outstanding, enabled and register free.
    assign elig = pend_q & ~mask_q & ~outs_q & {NUM_SRC{cfg_en & can_load}};

    msi_prio_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
        .req(elig),
        .gnt(take),
        .idx(win_idx),
        .any(win_any)
    );

    msi_req_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW), .GW(GW), .SRC_LOG(SRC_LOG)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_any),
        .idx     (win_idx),
        .addr_in (cfg_addr),
        .base_in (cfg_data),
        .glog    (cfg_grant_log2),
        .ready   (req_ready),
        .can_load(can_load),
        .valid   (req_valid),
        .addr    (req_addr),
        .data    (req_data)
    );

    assign pending_o = pend_q;
    assign mask_o    = mask_q;
endmodule

// File: rtl/msi_gen_chk.sv
// Assertion checker for msi_gen, attached by bind.
module msi_gen_chk #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DATA_W-1:0]  req_data,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] take,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] outs,
    input logic [NUM_SRC-1:0] mask
);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

    a_r8_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_valid) |-> $past(req_ready));

    a_r7_no_issue_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en && (!req_valid || req_ready) |=> !req_valid);

    a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));

    a_r5_eligible_only: assert property (@(posedge clk) disable iff (!rst_n)
        (take & (mask | outs | ~pend)) == '0);

    a_r4_mark_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |=> ((outs & $past(take)) == $past(take)));

    a_r9_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |=> ((pend & $past(take & ~src_evt)) == '0));
endmodule

bind msi_gen msi_gen_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_data (req_data),
    .src_evt  (src_evt),
    .take     (take),
    .pend     (pend_q),
    .outs     (outs_q),
    .mask     (mask_q)
);

// File: tb/msi_gen_tb.sv
// Self-checking bench: directed corner cases plus seeded random stimulus
// compared cycle by cycle with a model built from the requirements.
module msi_gen_tb;
    localparam int N  = 32;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [AW-1:0] caddr;
    logic [DW-1:0] cdata;
    logic [GW-1:0] grant;
    logic [N-1:0]  evt, svc, mset, mclr;
    logic          ready;
    logic          valid;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [N-1:0]  pend_o, mask_o;

    int checks = 0;
    int fails  = 0;

    // Model state.
    bit          m_valid;
    bit [AW-1:0] m_addr;
    bit [DW-1:0] m_data;
    bit [N-1:0]  m_pend, m_outs, m_mask;

    always #4 clk = ~clk;

    msi_gen #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_addr(caddr), .cfg_data(cdata),
        .cfg_grant_log2(grant), .src_evt(evt), .svc_ack(svc), .mask_set(mset),
        .mask_clr(mclr), .req_valid(valid), .req_ready(ready), .req_addr(raddr),
        .req_data(rdata), .pending_o(pend_o), .mask_o(mask_o)
    );

    function automatic bit [DW-1:0] fold(input bit [DW-1:0] base, input int g, input int src);
        int ge = (g > 5) ? 5 : g;
        bit [DW-1:0] m = DW'((1 << ge) - 1);
        return (base & ~m) | (DW'(src) & m);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs now applied.
    task automatic model_step();
        bit acc  = m_valid && ready;
        bit canl = !m_valid || acc;
        int win  = -1;
        if (canl && en)
            for (int i = 0; i < N; i++)
                if (win < 0 && m_pend[i] && !m_mask[i] && !m_outs[i]) win = i;
        if (win >= 0) begin
            m_valid = 1'b1;
            m_addr  = caddr;
            m_data  = fold(cdata, int'(grant), win);
        end else if (acc) begin
            m_valid = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            m_outs[i] = (win == i) ? 1'b1 : (svc[i] ? 1'b0 : m_outs[i]);
            m_pend[i] = evt[i] ? 1'b1 : ((win == i) ? 1'b0 : m_pend[i]);
            m_mask[i] = mset[i] ? 1'b1 : (mclr[i] ? 1'b0 : m_mask[i]);
        end
    endtask

    // One clock: model step, edge, compare at the falling edge, clear pulses.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        evt = '0; svc = '0; mset = '0; mclr = '0;
        chk(valid == m_valid, "R8", "req_valid", 64'(valid), 64'(m_valid));
        if (m_valid) begin
            chk(raddr == m_addr, "R3", "req_addr", 64'(raddr), 64'(m_addr));
            chk(rdata == m_data, "R3", "req_data", 64'(rdata), 64'(m_data));
        end
        chk(pend_o == m_pend, "R2", "pending_o", 64'(pend_o), 64'(m_pend));
        chk(mask_o == m_mask, "R5", "mask_o", 64'(mask_o), 64'(m_mask));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        rst_n = 1'b0; en = 1'b0; caddr = 32'hFEE0_1000; cdata = 16'hAB00; grant = 4'd3;
        evt = '0; svc = '0; mset = '0; mclr = '0; ready = 1'b0;
        m_valid = 0; m_addr = '0; m_data = '0; m_pend = '0; m_outs = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid == 1'b0, "R1", "req_valid after reset", 64'(valid), 64'd0);
        chk(pend_o == '0, "R1", "pending after reset", 64'(pend_o), 64'd0);
        chk(mask_o == '0, "R1", "mask after reset", 64'(mask_o), 64'd0);
        rst_n = 1'b1; en = 1'b1;

        // R2, R3, R9: event on source 13 with 8 messages granted.
        evt[13] = 1'b1; cycle();
        chk(pend_o[13] == 1'b1 && valid == 1'b0, "R2", "pending set, no request yet",
            64'({pend_o[13], valid}), 64'h2);
        cycle();
        chk(valid && rdata == 16'hAB05 && raddr == 32'hFEE0_1000, "R3", "folded data src13 g3",
            64'(rdata), 64'hAB05);
        chk(pend_o[13] == 1'b0, "R9", "pending cleared at issue", 64'(pend_o[13]), 64'd0);
        // R8: hold while not ready, R4: second event waits for the acknowledge.
        evt[13] = 1'b1; cycle();
        cycle();
        chk(valid && rdata == 16'hAB05, "R8", "request held while not ready", 64'(rdata), 64'hAB05);
        ready = 1'b1; cycle();
        chk(valid == 1'b0, "R4", "no resend while outstanding", 64'(valid), 64'd0);
        cycle(); cycle();
        chk(valid == 1'b0 && pend_o[13], "R4", "event kept pending while outstanding",
            64'({valid, pend_o[13]}), 64'h1);
        svc[13] = 1'b1; cycle();
        cycle();
        chk(valid == 1'b1 && rdata == 16'hAB05, "R4", "resent after acknowledge", 64'(rdata), 64'hAB05);
        ready = 1'b0; svc[13] = 1'b1; cycle();
        ready = 1'b1; cycle();

        // R6 and R3 clamp: grant 7 clamps to 5.
        ready = 1'b0; cdata = 16'hABFF; grant = 4'd7;
        evt[20] = 1'b1; evt[4] = 1'b1; cycle();
        cycle();
        chk(valid && rdata == 16'hABE4, "R6", "lowest index first", 64'(rdata), 64'hABE4);
        ready = 1'b1; cycle();
        chk(valid && rdata == 16'hABF4, "R3", "clamped fold src20", 64'(rdata), 64'hABF4);
        cycle();
        svc = 32'hFFFF_FFFF; cycle();

        // R5: masked event is held and sent after unmask.
        mset[6] = 1'b1; mclr[6] = 1'b1; cycle();
        chk(mask_o[6] == 1'b1, "R5", "set wins over clear", 64'(mask_o[6]), 64'd1);
        evt[6] = 1'b1; cycle(); cycle(); cycle();
        chk(valid == 1'b0 && pend_o[6], "R5", "masked source not sent", 64'({valid, pend_o[6]}), 64'h1);
        mclr[6] = 1'b1; cycle();
        cycle();
        chk(valid && rdata == 16'hABE6, "R5", "sent after unmask", 64'(rdata), 64'hABE6);
        cycle();

        // R7: disabled, events only pend.
        en = 1'b0; evt[9] = 1'b1; cycle(); cycle(); cycle();
        chk(valid == 1'b0 && pend_o[9], "R7", "no request while disabled", 64'({valid, pend_o[9]}), 64'h1);
        en = 1'b1; cycle();
        chk(valid && rdata == 16'hABE9, "R7", "sent after enable", 64'(rdata), 64'hABE9);
        svc = 32'hFFFF_FFFF; cycle();

        // Random phase.
        for (int c = 0; c < 4000; c++) begin
            if (c % 200 == 0) begin
                en    = ($urandom % 4) != 0;
                grant = GW'($urandom % 8);
                cdata = DW'($urandom);
                caddr = $urandom;
            end
            evt   = $urandom & $urandom & $urandom;
            svc   = $urandom & $urandom;
            mset  = ($urandom % 8 == 0) ? (32'h1 << ($urandom % 32)) : '0;
            mclr  = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : '0;
            ready = ($urandom % 10) < 7;
            cycle();
        end
        summary();
        $finish;
    end
endmodule